// File: doc/BRIEF.md
# Set/Clear Peripheral Clock Gate Controller

This block controls the gates of 64 peripheral clock branches, arranged as two groups of 32. Software never read-modify-writes a gate word. It writes a word of ones to a group's set port to open those gates, or to the group's clear port to close them. Bits written as zero leave their branches untouched, so separate drivers can share the block without a lock.

Each group keeps two views of its gates. The request word holds the state software last asked for. The status word holds the state the gate cells have acknowledged. The acknowledge is modelled as a fixed delay of `ACK_DELAY` cycles per branch. If a branch request is reversed before its delay runs out, the wait starts again. A driver polls the status word until the bit it changed matches its request. The acknowledged status of every branch drives one `gate_en` output bit.

A 32-bit register bus gives access to the four words of each group. Branch identifier k lives in group k/32 at bit k mod 32. A mask parameter marks branches as reserved; those branches can never open.

Top module: `clk_gate_ctrl`

## Requirements
- R1: A write to a group's set word (group 0 at 0x24, group 1 at 0x34) makes the request bit 1 for every data bit that is 1. All other request bits are unchanged.
- R2: A write to a group's clear word (group 0 at 0x28, group 1 at 0x38) makes the request bit 0 for every data bit that is 1. All other request bits are unchanged.
- R3: After a request bit changes at a clock edge, the matching status bit takes the new value exactly `ACK_DELAY` edges later. `gate_en` always equals the status words.
- R4: A request bit that returns to its status value before the delay runs out causes no status change. A later change starts a full new delay.
- R5: After reset, both the request and the status of each branch equal `RST_STATE` with the reserved branches forced to 0.
- R6: A branch marked in `RSVD_MASK` always reads 0 in request, in status and on `gate_en`, whatever is written.
- R7: Branch identifier k drives `gate_en[k]`. It is controlled through bit k mod 32 of group k/32.
- R8: Reads return the request word at 0x2C/0x3C and the status word at 0x30/0x40. Reads of the set and clear words, and of any other address, return 0.
- R9: Writes to the request, status or any unmapped address change no request or status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| gate_en | output | 64 | Acknowledged gate enable per branch |

## Verification
The bench builds the block with `ACK_DELAY` set to 3. That delay is long enough for a set followed by a clear, two cycles apart, to reverse a request while it is still pending. It also leaves a cycle in which the request and status words can be read while they differ. The reset state sets branches in both groups, and part of them are also marked reserved, so the masking of reset values can be seen directly. Reserved bits at 2 and 31 of group 0 and at 36–37 of group 1 test the edge and the interior of both words. A long pseudo-random run of set and clear writes is then compared every clock against a timestamp-based model.

// File: rtl/clkgate_pkg.sv
// Package: shared constants and types of the clock gate controller.
// Assumes a fixed two-group register layout of 32 branches per group.
package clkgate_pkg;
    localparam int GRP_BITS   = 32;
    localparam int NUM_GRP    = 2;
    localparam int NUM_BR     = GRP_BITS * NUM_GRP;
    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int BASE_OFS   = 'h24;
    localparam int GRP_STRIDE = 'h10;
    localparam int SET_OFS    = 'h0;
    localparam int CLR_OFS    = 'h4;
    localparam int REQ_OFS    = 'h8;
    localparam int STAT_OFS   = 'hC;

    // Per-group write command: one-hot-per-bit set and clear masks.
    typedef struct packed {
        logic [GRP_BITS-1:0] set_m;
        logic [GRP_BITS-1:0] clr_m;
    } grp_cmd_t;
endpackage

// File: rtl/clkgate_decode.sv
// Module: register bus decode for the gate controller.
// Turns a bus write into per-group set/clear masks and muxes read data.
// Assumes a single access per cycle and combinational read data.
module clkgate_decode
    import clkgate_pkg::*;
(
    input  logic                      bus_valid,
    input  logic                      bus_write,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    input  logic [NUM_BR-1:0]         req_v,
    input  logic [NUM_BR-1:0]         stat_v,
    output grp_cmd_t [NUM_GRP-1:0]    cmd,
    output logic [DATA_W-1:0]         bus_rdata
);
    logic wr_en;
    logic rd_en;
    logic [NUM_GRP-1:0] hit_req;
    logic [NUM_GRP-1:0] hit_stat;

    assign wr_en = bus_valid && bus_write;
    assign rd_en = bus_valid && !bus_write;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(BASE_OFS + g*GRP_STRIDE + SET_OFS);
        localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(BASE_OFS + g*GRP_STRIDE + CLR_OFS);
        localparam logic [ADDR_W-1:0] A_REQ  = ADDR_W'(BASE_OFS + g*GRP_STRIDE + REQ_OFS);
        localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE_OFS + g*GRP_STRIDE + STAT_OFS);

        // Write strobes: the data word becomes the set or clear mask.
        assign cmd[g].set_m = (wr_en && bus_addr == A_SET) ? bus_wdata : '0;
        assign cmd[g].clr_m = (wr_en && bus_addr == A_CLR) ? bus_wdata : '0;
        assign hit_req[g]   = rd_en && bus_addr == A_REQ;
        assign hit_stat[g]  = rd_en && bus_addr == A_STAT;
    end

    // Read mux: only request and status words return data.
    always_comb begin
        bus_rdata = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (hit_req[g])  bus_rdata = req_v[g*GRP_BITS +: GRP_BITS];
            if (hit_stat[g]) bus_rdata = stat_v[g*GRP_BITS +: GRP_BITS];
        end
    end
endmodule

// File: rtl/clkgate_group.sv
// Module: one group of gated clock branches.
// Holds the request word, and per branch a delay counter that copies the
// request into the status word ACK_DELAY cycles after it diverges.
// Assumes ACK_DELAY >= 1; reserved bits are held at 0.
module clkgate_group
    import clkgate_pkg::*;
#(
    parameter int                  ACK_DELAY = 4,
    parameter logic [GRP_BITS-1:0] RST_VAL   = '0,
    parameter logic [GRP_BITS-1:0] RSVD      = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  grp_cmd_t            cmd,
    output logic [GRP_BITS-1:0] req_q,
    output logic [GRP_BITS-1:0] stat_q
);
    localparam int                  CNT_W = $clog2(ACK_DELAY + 1);
    localparam logic [CNT_W-1:0]    LAST  = CNT_W'(ACK_DELAY - 1);
    localparam logic [GRP_BITS-1:0] INIT  = RST_VAL & ~RSVD;

    // Request word: clear has priority over set within one write.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= INIT;
        else        req_q <= (req_q | cmd.set_m) & ~cmd.clr_m & ~RSVD;
    end

    for (genvar b = 0; b < GRP_BITS; b++) begin : g_bit
        logic [CNT_W-1:0] cnt;
        logic             diff;
        assign diff = req_q[b] != stat_q[b];

        // Delay counter: runs while request and status differ, clears otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n)             cnt <= '0;
            else if (!diff)         cnt <= '0;
            else if (cnt == LAST)   cnt <= '0;
            else                    cnt <= cnt + 1'b1;
        end

        // Status bit: takes the request once the delay has run out.
        always_ff @(posedge clk) begin
            if (!rst_n)                  stat_q[b] <= INIT[b];
            else if (diff && cnt == LAST) stat_q[b] <= req_q[b];
        end
    end
endmodule

// File: rtl/clk_gate_ctrl.sv
// Module: top of the set/clear clock gate controller.
// Connects the bus decode to NUM_GRP branch groups and drives gate_en from
// the acknowledged status. Assumes a synchronous, active-low reset.
module clk_gate_ctrl
    import clkgate_pkg::*;
#(
    parameter int                ACK_DELAY = 4,
    parameter logic [NUM_BR-1:0] RST_STATE = '0,
    parameter logic [NUM_BR-1:0] RSVD_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_BR-1:0] gate_en
);
    grp_cmd_t [NUM_GRP-1:0] cmd;
    logic [NUM_BR-1:0]      req_all;
    logic [NUM_BR-1:0]      stat_all;

    clkgate_decode u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .req_v     (req_all),
        .stat_v    (stat_all),
        .cmd       (cmd),
        .bus_rdata (bus_rdata)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        clkgate_group #(
            .ACK_DELAY (ACK_DELAY),
            .RST_VAL   (RST_STATE[g*GRP_BITS +: GRP_BITS]),
            .RSVD      (RSVD_MASK[g*GRP_BITS +: GRP_BITS])
        ) u_grp (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd    (cmd[g]),
            .req_q  (req_all[g*GRP_BITS +: GRP_BITS]),
            .stat_q (stat_all[g*GRP_BITS +: GRP_BITS])
        );
    end

    assign gate_en = stat_all;
endmodule

// File: rtl/clkgate_chk.sv
// Module: assertion checker for clk_gate_ctrl, attached by bind.
// Observes the bus, the request vector and gate_en.
module clkgate_chk
    import clkgate_pkg::*;
#(
    parameter logic [NUM_BR-1:0] RSVD_MASK = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NUM_BR-1:0] req_all,
    input logic [NUM_BR-1:0] gate_en
);
    localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(BASE_OFS + SET_OFS);
    localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(BASE_OFS + CLR_OFS);
    localparam logic [ADDR_W-1:0] A_REQ1  = ADDR_W'(BASE_OFS + GRP_STRIDE + REQ_OFS);

    logic wr;
    assign wr = bus_valid && bus_write;

    // R6
    rsvd_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_en | req_all) & RSVD_MASK) == '0);

    // R3
    stat_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((gate_en ^ $past(gate_en)) & (gate_en ^ $past(req_all))) == '0);

    // R1
    set_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_SET0) |=>
        (req_all[GRP_BITS-1:0] & $past(bus_wdata)) ==
        ($past(bus_wdata) & ~RSVD_MASK[GRP_BITS-1:0]));

    // R2
    clr_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_CLR0) |=>
        (req_all[GRP_BITS-1:0] & $past(bus_wdata)) == '0);

    // R9
    ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_REQ1) |=> $stable(req_all));

    // R8
    wo_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && (bus_addr == A_SET0 || bus_addr == A_CLR0))
        |-> bus_rdata == '0);
endmodule

bind clk_gate_ctrl clkgate_chk #(.RSVD_MASK(RSVD_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .req_all   (req_all),
    .gate_en   (gate_en)
);

// File: tb/sim_clk_gate_ctrl.sv
// Bench: timestamp-based reference model compared with gate_en every clock,
// plus register read checks.
module sim_clk_gate_ctrl;
    localparam int          PERIOD = 10;
    localparam int          DLY    = 3;
    localparam logic [63:0] RST_V  = 64'h0000_00F0_0000_0005;
    localparam logic [63:0] RSV_V  = 64'h0000_0030_8000_0004;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] gate_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // Reference model state
    bit mreq [64];
    bit mstat[64];
    int pend [64];
    int cyc = 0;

    always #(PERIOD/2) clk = ~clk;

    clk_gate_ctrl #(.ACK_DELAY(DLY), .RST_STATE(RST_V), .RSVD_MASK(RSV_V)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .gate_en(gate_en)
    );

    // Model step on each edge: acknowledge first, then apply the bus write.
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0;
            for (int i = 0; i < 64; i++) begin
                mreq[i]  = RST_V[i] & ~RSV_V[i];
                mstat[i] = mreq[i];
                pend[i]  = 0;
            end
        end else begin
            cyc++;
            for (int i = 0; i < 64; i++) begin
                bit nr;
                int base;
                base = 'h24 + (i / 32) * 'h10;
                if (mreq[i] != mstat[i] && cyc - pend[i] == DLY) mstat[i] = mreq[i];
                nr = mreq[i];
                if (bus_valid && bus_write && bus_addr == 8'(base) && bus_wdata[i % 32]) nr = 1;
                if (bus_valid && bus_write && bus_addr == 8'(base + 4) && bus_wdata[i % 32]) nr = 0;
                if (RSV_V[i]) nr = 0;
                if (nr != mreq[i]) begin
                    mreq[i] = nr;
                    if (mreq[i] != mstat[i]) pend[i] = cyc;
                end
            end
        end
    end

    function automatic logic [63:0] model_stat();
        logic [63:0] v;
        for (int i = 0; i < 64; i++) v[i] = mstat[i];
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [7:0] a);
        logic [31:0] v = '0;
        for (int g = 0; g < 2; g++)
            for (int b = 0; b < 32; b++) begin
                if (a == 8'('h24 + g*'h10 + 8)) v[b] = mreq[g*32+b];
                if (a == 8'('h24 + g*'h10 + 'hC)) v[b] = mstat[g*32+b];
            end
        return v;
    endfunction

    // Per-clock comparison of gate_en against the model (R3 R4 R6 R7).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            total++;
            if (gate_en !== model_stat()) begin
                bad++;
                $display("FAIL R3 R4 R6 R7 cycle %0d gate_en actual=%h expected=%h",
                         cyc, gate_en, model_stat());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1;
        exp = model_read(a);
        total++;
        if (bus_rdata !== exp) begin
            bad++;
            $display("FAIL %s read addr %h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        rd_chk(8'h2C, tag); rd_chk(8'h30, tag);
        rd_chk(8'h3C, tag); rd_chk(8'h40, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=hung expected=done");
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rs;
        rs = 32'h1234_5678;
        wait_cyc(3);
        @(negedge clk) rst_n = 1;
        // R5: reset state of request and status
        read_all("R5");
        // R1 R6: set group-0 upper half plus a reserved bit
        wr(8'h24, 32'hFFFF_0004);
        read_all("R1 R3 pending");
        wait_cyc(DLY + 1);
        read_all("R1 R3 R6 settled");
        // R2: clear a group-1 bit
        wr(8'h38, 32'h0000_0040);
        wait_cyc(DLY + 1);
        read_all("R2");
        // R4: reverse a request before its delay runs out
        wr(8'h24, 32'h0000_0100);
        wr(8'h28, 32'h0000_0100);
        wait_cyc(DLY + 2);
        read_all("R4");
        // R7: identifier 40 is group 1 bit 8
        wr(8'h34, 32'h0000_0100);
        wait_cyc(DLY + 1);
        total++;
        if (gate_en[40] !== 1'b1) begin
            bad++;
            $display("FAIL R7 gate_en[40] actual=%b expected=1", gate_en[40]);
        end
        // R9: writes to request, status and unmapped words
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h40, 32'h0000_0000);
        wr(8'h00, 32'hFFFF_FFFF);
        wait_cyc(DLY + 1);
        read_all("R9");
        // R8: set/clear and unmapped reads return zero
        rd_chk(8'h24, "R8"); rd_chk(8'h28, "R8");
        rd_chk(8'h34, "R8"); rd_chk(8'h38, "R8");
        rd_chk(8'h44, "R8");
        // Pseudo-random set/clear traffic (R1 R2 R3 R4 R6)
        for (int k = 0; k < 400; k++) begin
            logic [7:0] a;
            rs = rs ^ (rs << 13); rs = rs ^ (rs >> 17); rs = rs ^ (rs << 5);
            case (rs[1:0])
                2'd0: a = 8'h24;
                2'd1: a = 8'h28;
                2'd2: a = 8'h34;
                default: a = 8'h38;
            endcase
            wr(a, rs & {rs[15:0], rs[31:16]});
            if (rs[7:5] == 3'd0) read_all("R1 R2 random");
        end
        wait_cyc(DLY + 2);
        read_all("R3 final");
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule